// File: doc/BRIEF.md
# Oversampled Console UART

A small serial console port for a system-on-chip. Bytes written by software queue in an 8-entry transmit FIFO and leave on `txOut` as asynchronous frames. Frames arriving on `rxIn` are collected into an 8-entry receive FIFO that software drains through the same register port. A frame has a low start bit, then 7 or 8 data bits sent least-significant first, then a high stop bit. There is no parity. The bit period is `8 * (divisor + 1)` system clocks, because a 16-bit divisor produces an oversample tick and each bit spans eight ticks.

The receiver confirms a start bit half a bit after the falling edge. It then samples each data bit at its centre. Once the last data bit has been taken, it waits half a bit and goes back to hunting for a start bit. It never looks at the stop bit, so an input line held low keeps producing 0x00 symbols and raises no error. Flow control can be run by software, or automatically: the ready line drops when the receive fill reaches a programmed level, and new frames are held back while the peer's clear-to-send input is low. A break bit forces the line low.

The register port is 32 bits wide with single-cycle access. Reads are combinational on `regAddr`, and a read strobe at address 0 pops the receive FIFO.

Register map:

| Address | Access | Contents |
|---|---|---|
| 0 | write | Push `regWdata[7:0]` into the transmit FIFO. |
| 0 | read | Pop the head of the receive FIFO. |
| 1 | read/write | Divisor low byte. |
| 2 | read/write | Divisor high byte. |
| 3 | read/write | Control register (fields below). |
| 4 | read/write | Ready level, in bits [3:0]. |
| 5 | read only | Status register (fields below). |
| 6 | read/write | Interrupt enables, in bits [1:0]. |
| 7 | reserved | Reads as 0. |

Control register fields (address 3):

| Bit | Name | Meaning |
|---|---|---|
| 0 | rxEn | Receiver enable. |
| 1 | txEn | Transmitter enable. |
| 2 | sevenBit | Select 7 data bits instead of 8. |
| 3 | breakOn | Force the transmit line low. |
| 4 | autoRts | Drive `rtsOut` from the receive fill level. |
| 5 | autoCts | Hold new frames while `ctsIn` is low. |
| 6 | swRts | Software value for `rtsOut`. |

Status register fields (address 5):

| Bits | Meaning |
|---|---|
| 0 | Receive data available. |
| 1 | Transmit space available. |
| 2 | Transmitter fully idle. |
| 3 | Synchronized `ctsIn`. |
| 4 | Receive FIFO full. |
| 5 | Transmit FIFO empty. |
| [11:8] | Receive FIFO count. |
| [15:12] | Transmit FIFO count. |

Top module: `conUart`

## Requirements
- R1: After reset the following hold. `txOut` is 1, `rtsOut` is 0 and `irqOut` is 0. The control register reads 0 and the divisor reads 0. With `ctsIn` low, status reads 0x26.
- R2: The transmitter sends a 0 start bit, then the data least-significant bit first, then a 1 stop bit. Each bit lasts exactly 8*(divisor+1) clocks, so a 0x00 byte in 8-bit mode gives a low run of 9 bit periods.
- R3: In 8-bit mode a frame received on `rxIn` is stored whole. It is read back at address 0 in first-in order.
- R4: With sevenBit set, a frame carries 7 data bits. The transmitter sends bits [6:0] of the written byte, and a received symbol is stored with bit 7 equal to 0.
- R5: The stop bit is never checked. With `rxIn` held low from idle at divisor 0, a 0x00 symbol is stored every 73 clocks, the first at about 71 clocks, so 260 clocks of low line leave exactly three 0x00 symbols.
- R6: A start bit is accepted only if the line is still low 4 oversample ticks after the falling edge. A shorter low pulse stores nothing.
- R7: Each FIFO holds 8 symbols. A write to a full transmit FIFO is dropped, and a symbol received while the receive FIFO is full is dropped. Status bit 1 clears when the transmit FIFO is full, and status bit 4 sets when the receive FIFO is full.
- R8: With autoRts set, `rtsOut` is 1 while the receive count is below the ready level and 0 otherwise. With autoRts clear, `rtsOut` follows swRts.
- R9: With autoCts set and `ctsIn` low, no new frame starts. A queued frame starts once `ctsIn` goes high.
- R10: While breakOn is set, `txOut` is 0 from the second clock after the write onward. It returns to 1 after breakOn is cleared.
- R11: A write to address 0 uses only `regWdata[7:0]`. A read of address 0 returns the symbol in bits [7:0] with zeros above.
- R12: Bits outside the defined fields read back as 0 and have no effect: control bits [31:7], level bits [31:4], divisor register bits [31:8] and enable bits [31:2]. Writes to status and to address 7 are ignored.
- R13: `irqOut` is (enable bit 0 AND receive data available) OR (enable bit 1 AND transmit FIFO empty).
- R14: `ctsIn` and `rxIn` pass through two flip-flops. A change of `ctsIn` shows in status bit 3 after the second rising clock edge and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe; pops the receive FIFO at address 0 |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational on regAddr |
| rxIn | input | 1 | Serial input |
| ctsIn | input | 1 | Peer clear-to-send, high allows sending |
| txOut | output | 1 | Serial output, idle high |
| rtsOut | output | 1 | Ready to receive, high allows the peer to send |
| irqOut | output | 1 | Level interrupt |

## Verification
A wrong oversample phase or bit counter in the receiver shows at the port as a corrupted or shifted byte on the very next read of address 0. A receiver stuck outside its hunting state shows as a missing symbol within one frame time. A slip in the transmit counter stretches or shrinks a bit period, which the bench sees in the same frame by sampling each bit at its centre and by measuring the exact low run of a 0x00 frame. FIFO pointer or count errors show in the status count fields and in out-of-order data, so frames are sent in sweeps across divisors, widths and byte values, with the FIFOs driven through full and empty.

// File: rtl/conUartPkg.sv
package conUartPkg;
  localparam int DATA_W     = 8;
  localparam int FIFO_DEPTH = 8;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
  localparam int DIV_W      = 16;
  localparam int BUS_W      = 32;
  localparam int ADDR_W     = 3;
  localparam int OVS        = 8;

  localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIVLO = 3'd1;
  localparam logic [ADDR_W-1:0] A_DIVHI = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_LEVEL = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd5;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd6;

  typedef struct packed {
    logic [DIV_W-1:0] divisor;
    logic             rxEn;
    logic             txEn;
    logic             sevenBit;
    logic             breakOn;
    logic             autoRts;
    logic             autoCts;
    logic             swRts;
    logic [CNT_W-1:0] rtsLevel;
  } cfg_t;

  typedef struct packed {
    logic              pushTx;
    logic              popRx;
    logic [DATA_W-1:0] txByte;
  } strb_t;

  typedef struct packed {
    cfg_t  cfg;
    strb_t strb;
  } ctlBus_t;

  typedef struct packed {
    logic [DATA_W-1:0] rxHead;
    logic [CNT_W-1:0]  rxCount;
    logic [CNT_W-1:0]  txCount;
    logic              rxEmpty;
    logic              rxFull;
    logic              txEmpty;
    logic              txFull;
    logic              txBusy;
    logic              ctsSync;
  } stat_t;
endpackage

// File: rtl/conUartFifo.sv
module conUartFifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPop  = pop && !empty;
  assign doPush = push && (!full || doPop);
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  // R7: a push into a full queue without a pop changes neither fill nor head
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> (count == $past(count) && head == $past(head)));

  // R7: a pop from an empty queue leaves it empty
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/conUartCtrl.sv
module conUartCtrl
  import conUartPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]  regWdata,
  output logic [BUS_W-1:0]  regRdata,
  input  stat_t             stat,
  output ctlBus_t           ctl,
  output logic              irqOut
);
  logic [DATA_W-1:0] divLo, divHi;
  logic [6:0]        ctrlQ;
  logic [CNT_W-1:0]  levelQ;
  logic [1:0]        ienQ;
  logic              unusedBits;

  assign unusedBits = ^regWdata[BUS_W-1:DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divLo  <= '0;
      divHi  <= '0;
      ctrlQ  <= '0;
      levelQ <= CNT_W'(FIFO_DEPTH);
      ienQ   <= '0;
    end else if (regWr) begin
      unique case (regAddr)
        A_DIVLO: divLo  <= regWdata[DATA_W-1:0];
        A_DIVHI: divHi  <= regWdata[DATA_W-1:0];
        A_CTRL:  ctrlQ  <= regWdata[6:0];
        A_LEVEL: levelQ <= regWdata[CNT_W-1:0];
        A_IEN:   ienQ   <= regWdata[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl.cfg.divisor  = {divHi, divLo};
    ctl.cfg.rxEn     = ctrlQ[0];
    ctl.cfg.txEn     = ctrlQ[1];
    ctl.cfg.sevenBit = ctrlQ[2];
    ctl.cfg.breakOn  = ctrlQ[3];
    ctl.cfg.autoRts  = ctrlQ[4];
    ctl.cfg.autoCts  = ctrlQ[5];
    ctl.cfg.swRts    = ctrlQ[6];
    ctl.cfg.rtsLevel = levelQ;
    ctl.strb.pushTx  = regWr && (regAddr == A_DATA);
    ctl.strb.txByte  = regWdata[DATA_W-1:0];
    ctl.strb.popRx   = regRd && (regAddr == A_DATA) && !stat.rxEmpty;
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      A_DATA:  regRdata[DATA_W-1:0] = stat.rxEmpty ? '0 : stat.rxHead;
      A_DIVLO: regRdata[DATA_W-1:0] = divLo;
      A_DIVHI: regRdata[DATA_W-1:0] = divHi;
      A_CTRL:  regRdata[6:0]        = ctrlQ;
      A_LEVEL: regRdata[CNT_W-1:0]  = levelQ;
      A_IEN:   regRdata[1:0]        = ienQ;
      A_STAT: begin
        regRdata[0]          = !stat.rxEmpty;
        regRdata[1]          = !stat.txFull;
        regRdata[2]          = stat.txEmpty && !stat.txBusy;
        regRdata[3]          = stat.ctsSync;
        regRdata[4]          = stat.rxFull;
        regRdata[5]          = stat.txEmpty;
        regRdata[8 +: CNT_W]  = stat.rxCount;
        regRdata[12 +: CNT_W] = stat.txCount;
      end
      default: regRdata = '0;
    endcase
  end

  assign irqOut = (ienQ[0] && !stat.rxEmpty) || (ienQ[1] && stat.txEmpty);
endmodule

// File: rtl/conUartDatapath.sv
module conUartDatapath
  import conUartPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  ctlBus_t ctl,
  input  logic    rxIn,
  input  logic    ctsIn,
  output logic    txOut,
  output logic    rtsOut,
  output stat_t   stat
);
  localparam int TICK_W = $clog2(OVS);
  localparam int HALF   = OVS / 2;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int LEFT_W = $clog2(DATA_W + 3);
  localparam int FRM_W  = DATA_W + 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_GAP} rxState_t;
  typedef enum logic {TX_IDLE, TX_SEND} txState_t;

  // two-flop input synchronizers
  logic rxMeta, rxSync, ctsMeta, ctsSync;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1; rxSync <= 1'b1;
      ctsMeta <= 1'b0; ctsSync <= 1'b0;
    end else begin
      rxMeta <= rxIn;   rxSync <= rxMeta;
      ctsMeta <= ctsIn; ctsSync <= ctsMeta;
    end
  end

  // oversample tick generator
  logic [DIV_W-1:0] divCnt;
  logic tick;
  assign tick = (divCnt >= ctl.cfg.divisor);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // receive FSM
  rxState_t rxState;
  logic [TICK_W-1:0] rxTick;
  logic [BIT_W-1:0]  rxBit, lastBit;
  logic [DATA_W-2:0] rxShift;
  logic [DATA_W-1:0] rxShiftNext, rxPushData;
  logic rxPush, rxEmpty, rxFull;
  logic [CNT_W-1:0] rxCount;
  logic [DATA_W-1:0] rxHead;

  assign lastBit     = ctl.cfg.sevenBit ? BIT_W'(DATA_W - 2) : BIT_W'(DATA_W - 1);
  assign rxShiftNext = {rxSync, rxShift};
  assign rxPushData  = ctl.cfg.sevenBit ? {1'b0, rxShiftNext[DATA_W-1:1]} : rxShiftNext;
  assign rxPush      = tick && (rxState == RX_DATA) && (rxTick == TICK_W'(OVS - 1))
                       && (rxBit == lastBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxTick  <= '0;
      rxBit   <= '0;
      rxShift <= '0;
    end else if (tick) begin
      unique case (rxState)
        RX_IDLE: if (ctl.cfg.rxEn && !rxSync) begin
          rxState <= RX_START;
          rxTick  <= '0;
        end
        RX_START: if (rxTick == TICK_W'(HALF - 1)) begin
          rxState <= rxSync ? RX_IDLE : RX_DATA;
          rxTick  <= '0;
          rxBit   <= '0;
        end else rxTick <= rxTick + 1'b1;
        RX_DATA: begin
          rxTick <= rxTick + 1'b1;
          if (rxTick == TICK_W'(OVS - 1)) begin
            rxShift <= rxShiftNext[DATA_W-1:1];
            if (rxBit == lastBit) begin
              rxState <= RX_GAP;
              rxTick  <= '0;
            end else rxBit <= rxBit + 1'b1;
          end
        end
        RX_GAP: if (rxTick == TICK_W'(HALF - 1)) begin
          rxState <= RX_IDLE;
          rxTick  <= '0;
        end else rxTick <= rxTick + 1'b1;
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  conUartFifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN), .push(rxPush), .din(rxPushData), .pop(ctl.strb.popRx),
    .head(rxHead), .count(rxCount), .empty(rxEmpty), .full(rxFull));

  // transmit FSM
  txState_t txState;
  logic [TICK_W-1:0] txTick;
  logic [LEFT_W-1:0] txLeft;
  logic [FRM_W-1:0]  txShift;
  logic [DATA_W-1:0] txHead;
  logic [CNT_W-1:0]  txCount;
  logic txEmpty, txFull, txStart;

  assign txStart = tick && (txState == TX_IDLE) && ctl.cfg.txEn && !txEmpty
                   && (!ctl.cfg.autoCts || ctsSync);

  conUartFifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN), .push(ctl.strb.pushTx), .din(ctl.strb.txByte), .pop(txStart),
    .head(txHead), .count(txCount), .empty(txEmpty), .full(txFull));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txTick  <= '0;
      txLeft  <= '0;
      txShift <= '1;
    end else if (txStart) begin
      txState <= TX_SEND;
      txTick  <= '0;
      if (ctl.cfg.sevenBit) begin
        txShift <= {2'b11, txHead[DATA_W-2:0], 1'b0};
        txLeft  <= LEFT_W'(FRM_W - 1);
      end else begin
        txShift <= {1'b1, txHead, 1'b0};
        txLeft  <= LEFT_W'(FRM_W);
      end
    end else if (tick && txState == TX_SEND) begin
      txTick <= txTick + 1'b1;
      if (txTick == TICK_W'(OVS - 1)) begin
        txShift <= {1'b1, txShift[FRM_W-1:1]};
        txLeft  <= txLeft - 1'b1;
        if (txLeft == LEFT_W'(1)) txState <= TX_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                txOut <= 1'b1;
    else if (ctl.cfg.breakOn) txOut <= 1'b0;
    else                      txOut <= (txState == TX_SEND) ? txShift[0] : 1'b1;
  end

  assign rtsOut = ctl.cfg.autoRts ? (rxCount < ctl.cfg.rtsLevel) : ctl.cfg.swRts;

  always_comb begin
    stat.rxHead  = rxHead;
    stat.rxCount = rxCount;
    stat.txCount = txCount;
    stat.rxEmpty = rxEmpty;
    stat.rxFull  = rxFull;
    stat.txEmpty = txEmpty;
    stat.txFull  = txFull;
    stat.txBusy  = (txState == TX_SEND);
    stat.ctsSync = ctsSync;
  end

  // R9: an idle transmitter stays idle while automatic CTS blocks it
  p_cts_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (txState == TX_IDLE && ctl.cfg.autoCts && !ctsSync) |=> (txState == TX_IDLE));

  // R10: break forces the line low on the following cycle
  p_break_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.cfg.breakOn) |-> !txOut);

  // R5: the receiver returns to hunting right after its half-bit gap
  p_gap_to_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tick && rxState == RX_GAP && rxTick == TICK_W'(HALF - 1)) |=> (rxState == RX_IDLE));

  // R6: a start that is high at its confirmation point is abandoned
  p_false_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && rxState == RX_START && rxTick == TICK_W'(HALF - 1) && rxSync)
      |=> (rxState == RX_IDLE));
endmodule

// File: rtl/conUart.sv
module conUart
  import conUartPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]  regWdata,
  output logic [BUS_W-1:0]  regRdata,
  input  logic              rxIn,
  input  logic              ctsIn,
  output logic              txOut,
  output logic              rtsOut,
  output logic              irqOut
);
  ctlBus_t ctl;
  stat_t   stat;

  conUartCtrl uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .stat(stat), .ctl(ctl), .irqOut(irqOut));

  conUartDatapath uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxIn(rxIn), .ctsIn(ctsIn),
    .txOut(txOut), .rtsOut(rtsOut), .stat(stat));
endmodule

// File: tb/sim_conUart.sv
module sim_conUart;
  logic clk = 1'b0;
  logic rstN, regWr, regRd, rxIn, ctsIn;
  logic [2:0] regAddr;
  logic [31:0] regWdata, regRdata;
  logic txOut, rtsOut, irqOut;
  int errs = 0;
  int checks = 0;

  always #4 clk = ~clk;

  conUart u0 (.clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .rxIn(rxIn), .ctsIn(ctsIn),
    .txOut(txOut), .rtsOut(rtsOut), .irqOut(irqOut));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic sendRx(input logic [7:0] b, input int nb, input int div);
    int bl = 8 * (div + 1);
    @(negedge clk);
    rxIn = 1'b0; cyc(bl);
    for (int i = 0; i < nb; i++) begin rxIn = b[i]; cyc(bl); end
    rxIn = 1'b1; cyc(bl);
  endtask

  task automatic recvTx(input int nb, input int div, output logic [7:0] got, output logic ok);
    int t = 0;
    int bl = 8 * (div + 1);
    got = '0; ok = 1'b1;
    while (txOut !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
    if (t >= 4000) ok = 1'b0;
    else begin
      cyc(bl / 2);
      if (txOut !== 1'b0) ok = 1'b0;
      for (int i = 0; i < nb; i++) begin cyc(bl); got[i] = txOut; end
      cyc(bl);
      if (txOut !== 1'b1) ok = 1'b0;
    end
  endtask

  task automatic drainRx();
    logic [31:0] s, d;
    rdReg(3'd5, s);
    while (s[0]) begin rdReg(3'd0, d); rdReg(3'd5, s); end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, s;
    logic [7:0] got, b;
    logic ok, stayed;
    int lowRun;
    rstN = 1'b0; regWr = 1'b0; regRd = 1'b0; regAddr = '0; regWdata = '0;
    rxIn = 1'b1; ctsIn = 1'b0;
    cyc(4); rstN = 1'b1; cyc(2);

    // R1 reset state
    chk("R1 txOut", {31'b0, txOut}, 32'd1);
    chk("R1 rtsOut", {31'b0, rtsOut}, 32'd0);
    chk("R1 irqOut", {31'b0, irqOut}, 32'd0);
    rdReg(3'd5, d); chk("R1 status", d, 32'h26);
    rdReg(3'd3, d); chk("R1 control", d, 32'h0);
    rdReg(3'd1, d); chk("R1 divisor", d, 32'h0);

    // R14 sync latency on cts
    @(negedge clk); regAddr = 3'd5; ctsIn = 1'b1;
    @(negedge clk); chk("R14 cts after one edge", {31'b0, regRdata[3]}, 32'd0);
    @(negedge clk); chk("R14 cts after two edges", {31'b0, regRdata[3]}, 32'd1);
    ctsIn = 1'b0; cyc(3);

    // R3/R4 sweep over divisor, width and byte value in both directions
    for (int div = 0; div < 3; div++) begin
      for (int m = 0; m < 2; m++) begin
        wrReg(3'd1, 32'(div));
        wrReg(3'd3, (m == 1) ? 32'h7 : 32'h3);
        for (int k = 0; k < 6; k++) begin
          b = 8'((k * 73) + (div * 29) + (m * 101) + 8'h35);
          wrReg(3'd0, {24'h0, b});
          recvTx((m == 1) ? 7 : 8, div, got, ok);
          chk(m == 1 ? "R4 tx 7-bit frame" : "R3 tx 8-bit frame", {23'b0, ok, got},
              {23'b0, 1'b1, (m == 1) ? (b & 8'h7f) : b});
          sendRx(b ^ 8'hA5, (m == 1) ? 7 : 8, div);
          rdReg(3'd0, d);
          chk(m == 1 ? "R4 rx 7-bit msb zero" : "R3 rx 8-bit frame", d,
              {24'h0, (m == 1) ? ((b ^ 8'hA5) & 8'h7f) : (b ^ 8'hA5)});
        end
      end
    end

    // R2 exact bit period: 0x00 at divisor 2 gives 9*24 low clocks
    wrReg(3'd1, 32'd2); wrReg(3'd3, 32'h2);
    wrReg(3'd0, 32'h0);
    while (txOut !== 1'b0) @(negedge clk);
    lowRun = 0;
    while (txOut === 1'b0 && lowRun < 1000) begin @(negedge clk); lowRun++; end
    chk("R2 low run of zero byte", 32'(lowRun), 32'd216);
    cyc(40);

    // R5 held low line gives three 0x00 symbols in 260 clocks at divisor 0
    wrReg(3'd1, 32'd0); wrReg(3'd3, 32'h1);
    @(negedge clk); rxIn = 1'b0; cyc(260);
    rdReg(3'd5, d); chk("R5 rx count after low line", {28'b0, d[11:8]}, 32'd3);
    for (int i = 0; i < 3; i++) begin
      rdReg(3'd0, d); chk("R5 low line symbol", d, 32'h0);
    end
    rxIn = 1'b1; cyc(200); drainRx();

    // R6 short low pulse is not a start
    wrReg(3'd1, 32'd1);
    @(negedge clk); rxIn = 1'b0; cyc(4); rxIn = 1'b1; cyc(200);
    rdReg(3'd5, d); chk("R6 glitch stores nothing", {31'b0, d[0]}, 32'd0);

    // R7 transmit depth
    wrReg(3'd1, 32'd0); wrReg(3'd3, 32'h0);
    for (int i = 0; i < 10; i++) wrReg(3'd0, 32'h10 + 32'(i));
    rdReg(3'd5, d);
    chk("R7 tx count full", {28'b0, d[15:12]}, 32'd8);
    chk("R7 tx space clear", {31'b0, d[1]}, 32'd0);
    wrReg(3'd3, 32'h2);
    for (int i = 0; i < 8; i++) begin
      recvTx(8, 0, got, ok);
      chk("R7 tx order", {23'b0, ok, got}, {23'b0, 1'b1, 8'h10 + 8'(i)});
    end
    stayed = 1'b1;
    cyc(8);
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (txOut !== 1'b1) stayed = 1'b0; end
    chk("R7 dropped writes not sent", {31'b0, stayed}, 32'd1);

    // R7 receive depth
    wrReg(3'd3, 32'h1);
    for (int i = 0; i < 10; i++) sendRx(8'h40 + 8'(i), 8, 0);
    rdReg(3'd5, d);
    chk("R7 rx count full", {28'b0, d[11:8]}, 32'd8);
    chk("R7 rx full flag", {31'b0, d[4]}, 32'd1);
    for (int i = 0; i < 8; i++) begin
      rdReg(3'd0, d); chk("R7 rx order", d, 32'h40 + 32'(i));
    end
    rdReg(3'd5, d); chk("R7 rx empty after drain", {31'b0, d[0]}, 32'd0);

    // R8 automatic and manual ready line
    wrReg(3'd4, 32'd3); wrReg(3'd3, 32'h11);
    chk("R8 rts below level", {31'b0, rtsOut}, 32'd1);
    for (int i = 0; i < 3; i++) sendRx(8'h21, 8, 0);
    chk("R8 rts at level", {31'b0, rtsOut}, 32'd0);
    rdReg(3'd0, d);
    chk("R8 rts after pop", {31'b0, rtsOut}, 32'd1);
    drainRx();
    wrReg(3'd3, 32'h40); chk("R8 manual rts high", {31'b0, rtsOut}, 32'd1);
    wrReg(3'd3, 32'h0);  chk("R8 manual rts low", {31'b0, rtsOut}, 32'd0);

    // R9 automatic CTS hold
    ctsIn = 1'b0;
    wrReg(3'd3, 32'h22); wrReg(3'd0, 32'h5C);
    stayed = 1'b1;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (txOut !== 1'b1) stayed = 1'b0; end
    chk("R9 held while cts low", {31'b0, stayed}, 32'd1);
    ctsIn = 1'b1;
    recvTx(8, 0, got, ok);
    chk("R9 sent after cts high", {23'b0, ok, got}, {23'b0, 1'b1, 8'h5C});
    cyc(20);

    // R10 break
    wrReg(3'd3, 32'hA); cyc(1);
    chk("R10 break low", {31'b0, txOut}, 32'd0);
    cyc(20);
    chk("R10 break still low", {31'b0, txOut}, 32'd0);
    wrReg(3'd3, 32'h2); cyc(1);
    chk("R10 break released", {31'b0, txOut}, 32'd1);

    // R11 data register width
    wrReg(3'd3, 32'h3); wrReg(3'd0, 32'hABCDEF5A);
    recvTx(8, 0, got, ok);
    chk("R11 only low byte sent", {23'b0, ok, got}, {23'b0, 1'b1, 8'h5A});
    sendRx(8'hC3, 8, 0);
    rdReg(3'd0, d); chk("R11 read zero-extended", d, 32'h000000C3);

    // R12 unsupported bits
    wrReg(3'd3, 32'hFFFFFF80);
    rdReg(3'd3, d); chk("R12 control upper bits", d, 32'h0);
    chk("R12 no effect on line", {30'b0, txOut, rtsOut}, 32'h2);
    wrReg(3'd3, 32'hFFFFFFC0);
    rdReg(3'd3, d); chk("R12 control swRts only", d, 32'h40);
    wrReg(3'd4, 32'hFFF5);
    rdReg(3'd4, d); chk("R12 level field", d, 32'h5);
    wrReg(3'd1, 32'hFFFFFF07);
    rdReg(3'd1, d); chk("R12 divisor byte", d, 32'h7);
    wrReg(3'd6, 32'hFC);
    rdReg(3'd6, d); chk("R12 enable field", d, 32'h0);
    rdReg(3'd5, s); wrReg(3'd5, 32'hFF);
    rdReg(3'd5, d); chk("R12 status write ignored", d, s);
    wrReg(3'd7, 32'hFFFFFFFF);
    rdReg(3'd7, d); chk("R12 reserved reads zero", d, 32'h0);
    wrReg(3'd1, 32'd0); wrReg(3'd3, 32'h0);

    // R13 interrupt
    wrReg(3'd6, 32'h1); wrReg(3'd3, 32'h1);
    chk("R13 no irq when empty", {31'b0, irqOut}, 32'd0);
    sendRx(8'h77, 8, 0);
    chk("R13 irq on rx data", {31'b0, irqOut}, 32'd1);
    rdReg(3'd0, d);
    chk("R13 irq cleared by read", {31'b0, irqOut}, 32'd0);
    wrReg(3'd6, 32'h2);
    chk("R13 irq on tx empty", {31'b0, irqOut}, 32'd1);
    wrReg(3'd0, 32'h11);
    chk("R13 irq off when tx queued", {31'b0, irqOut}, 32'd0);
    wrReg(3'd3, 32'h2);
    recvTx(8, 0, got, ok);
    chk("R13 queued byte sent", {23'b0, ok, got}, {23'b0, 1'b1, 8'h11});

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule